// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR flash bus. It runs one program or sector-erase operation for each accepted start request. It first issues the unlock and command write cycles on the address, data, chip-enable, output-enable and write-enable lines. It then watches the flash status byte until it can decide whether the operation finished or failed.

Completion is decided with the toggle-bit method, with no ready/busy pin and no fixed delay. The bit at position 6 is compared across two back-to-back reads. While that bit keeps toggling, the timeout flag at bit 5 decides whether polling goes on or whether a final confirmation pair of reads is taken. After a successful erase, the target location is read back and must hold all ones. A failure of any kind makes the block write the reset command, so the flash returns to array-read mode. The host sees a one-cycle `done` pulse. The `pass` or `fail` level stays valid until the next request is accepted.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is high and afterwards until a start is accepted, `f_ce_n`, `f_oe_n` and `f_we_n` are 1, `f_dq_oe` is 0, and `done`, `pass` and `fail` are 0.
- R2: A program request (`op_erase`=0) issues exactly four write cycles, in this order: 8'hAA at 17'h555, 8'h55 at 17'h2AA, 8'hA0 at 17'h555, then `wr_data` at `tgt_addr`.
- R3: An erase request (`op_erase`=1) issues exactly six write cycles, in this order: AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 8'h30 at `tgt_addr`.
- R4: In every write cycle, `f_ce_n` is low, `f_oe_n` is high and `f_we_n` is low for exactly WR_LOW_CLKS clocks. Address and data are unchanged at the clock where `f_we_n` rises. `f_dq_oe` is never 1 while `f_oe_n` is 0.
- R5: After the command, the block reads `tgt_addr` twice. If bit 6 matches in both reads, the operation counts as complete, and a program operation then ends with pass.
- R6: If bit 6 differs and bit 5 of the second read is 0, another pair of reads follows.
- R7: If bit 6 differs and bit 5 of the second read is 1, two more reads are taken. If bit 6 matches across them, the operation is complete. If it differs, the result is fail.
- R8: A completed erase is followed by one read of `tgt_addr`. The result is pass only if that read returns 8'hFF; any other value gives fail.
- R9: Every fail result is preceded by one extra write cycle of 8'hF0 at address 0, issued after all status reads.
- R10: The POLL_LIMIT-th read pair that shows toggling with bit 5 at 0 ends the run with fail, with no further reads. A pair that matches before that count is reached still completes normally.
- R11: `done` is high for exactly one clock per run, together with exactly one of `pass`/`fail`. That level holds until the next accepted start, which clears both.
- R12: A `start` raised while a run is in progress has no effect on the bus cycles or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| op_erase | input | 1 | 0 = program, 1 = sector erase |
| tgt_addr | input | ADDR_W | Program address or sector address |
| wr_data | input | DATA_W | Byte to program |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run succeeded (held) |
| fail | output | 1 | Run failed (held) |
| f_addr | output | ADDR_W | Flash address lines |
| f_dq_o | output | DATA_W | Data driven to flash |
| f_dq_oe | output | 1 | Data output enable toward flash |
| f_dq_i | input | DATA_W | Data read from flash |
| f_ce_n | output | 1 | Chip enable, active low |
| f_oe_n | output | 1 | Output enable, active low |
| f_we_n | output | 1 | Write enable, active low |

## Verification
Two decisions can be reached on the same evaluation, and the bench provokes both. In the first case, the timeout flag rises on the very read where the status bit stops toggling. The flash model raises bit 5 on the last busy read, and the bench expects a pass after exactly one confirmation pair. In the second case, the poll limit and a settled pair collide. The model stops toggling one pair before the limit in one vector and exactly at the limit in another. One must pass and the other must fail, and both are judged by the result together with the exact number of status reads and the presence or absence of the reset write.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int BIT_TOGGLE  = 6;
    localparam int BIT_TIMEOUT = 5;

    localparam logic [7:0] BYTE_ERASED = 8'hFF;
    localparam logic [7:0] BYTE_RESET  = 8'hF0;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_PASS,
        RES_FAIL
    } result_e;

    typedef enum logic [3:0] {
        C_IDLE,
        C_CMD,
        C_POLL1,
        C_POLL2,
        C_CONF1,
        C_CONF2,
        C_VERIFY,
        C_ABORT,
        C_DONE
    } ctl_state_e;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_SETUP,
        BUS_WLOW,
        BUS_HOLD,
        BUS_READ
    } bus_state_e;

    typedef struct packed {
        logic [11:0] unlock_addr;
        logic        at_target;
        logic [7:0]  byte_val;
        logic        final_step;
    } cmd_word_t;

    function automatic cmd_word_t cmd_word(op_e op, logic [2:0] step, logic [7:0] wdata);
        cmd_word_t w;
        w = '0;
        if (op == OP_PROGRAM) begin
            case (step)
                3'd0:    begin w.unlock_addr = 12'h555; w.byte_val = 8'hAA; end
                3'd1:    begin w.unlock_addr = 12'h2AA; w.byte_val = 8'h55; end
                3'd2:    begin w.unlock_addr = 12'h555; w.byte_val = 8'hA0; end
                default: begin w.at_target = 1'b1; w.byte_val = wdata; w.final_step = 1'b1; end
            endcase
        end else begin
            case (step)
                3'd0:    begin w.unlock_addr = 12'h555; w.byte_val = 8'hAA; end
                3'd1:    begin w.unlock_addr = 12'h2AA; w.byte_val = 8'h55; end
                3'd2:    begin w.unlock_addr = 12'h555; w.byte_val = 8'h80; end
                3'd3:    begin w.unlock_addr = 12'h555; w.byte_val = 8'hAA; end
                3'd4:    begin w.unlock_addr = 12'h2AA; w.byte_val = 8'h55; end
                default: begin w.at_target = 1'b1; w.byte_val = 8'h30; w.final_step = 1'b1; end
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/fpc_cmd_seq.sv
module fpc_cmd_seq
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] target,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data,
    output logic              cyc_last
);

    cmd_word_t word;

    always_comb begin
        word     = cmd_word(op, step, wdata[7:0]);
        cyc_addr = word.at_target ? target : ADDR_W'(word.unlock_addr);
        cyc_data = DATA_W'(word.byte_val);
        cyc_last = word.final_step;
    end

endmodule

// File: rtl/fpc_bus_engine.sv
module fpc_bus_engine
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int WR_LOW_CLKS = 3,
    parameter int RD_ACC_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] f_addr,
    output logic [DATA_W-1:0] f_dq_o,
    output logic              f_dq_oe,
    input  logic [DATA_W-1:0] f_dq_i,
    output logic              f_ce_n,
    output logic              f_oe_n,
    output logic              f_we_n
);

    localparam int LONGEST = (WR_LOW_CLKS > RD_ACC_CLKS) ? WR_LOW_CLKS : RD_ACC_CLKS;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_LOW_CLKS - 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_ACC_CLKS - 1);

    bus_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= BUS_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            data_q <= '0;
            wr_q   <= 1'b0;
        end else begin
            case (state)
                BUS_IDLE: begin
                    cnt <= '0;
                    if (req) begin
                        addr_q <= req_addr;
                        data_q <= req_data;
                        wr_q   <= req_wr;
                        state  <= req_wr ? BUS_SETUP : BUS_READ;
                    end
                end
                BUS_SETUP: begin
                    cnt   <= '0;
                    state <= BUS_WLOW;
                end
                BUS_WLOW: begin
                    if (cnt == WR_LAST) begin
                        cnt   <= '0;
                        state <= BUS_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                BUS_HOLD: begin
                    state <= BUS_IDLE;
                end
                BUS_READ: begin
                    if (cnt == RD_LAST) begin
                        cnt   <= '0;
                        state <= BUS_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= BUS_IDLE;
            endcase
        end
    end

    always_comb begin
        f_ce_n  = (state == BUS_IDLE);
        f_we_n  = (state != BUS_WLOW);
        f_oe_n  = (state != BUS_READ);
        f_dq_oe = wr_q && ((state == BUS_SETUP) || (state == BUS_WLOW) || (state == BUS_HOLD));
        f_addr  = addr_q;
        f_dq_o  = data_q;
        ack     = (state == BUS_HOLD) || ((state == BUS_READ) && (cnt == RD_LAST));
        rd_data = f_dq_i;
    end

endmodule

// File: rtl/fpc_status_judge.sv
module fpc_status_judge
    import flash_poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              first_tog,
    input  logic [DATA_W-1:0] second,
    output logic              settled,
    output logic              timed_out,
    output logic              erased_ok
);

    always_comb begin
        settled   = (first_tog == second[BIT_TOGGLE]);
        timed_out = second[BIT_TIMEOUT];
        erased_ok = (second == DATA_W'(BYTE_ERASED));
    end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int WR_LOW_CLKS = 3,
    parameter int RD_ACC_CLKS = 4,
    parameter int POLL_LIMIT  = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_erase,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] f_addr,
    output logic [DATA_W-1:0] f_dq_o,
    output logic              f_dq_oe,
    input  logic [DATA_W-1:0] f_dq_i,
    output logic              f_ce_n,
    output logic              f_oe_n,
    output logic              f_we_n
);

    localparam int PCNT_W = $clog2(POLL_LIMIT + 1);
    localparam logic [PCNT_W-1:0] POLL_LAST = PCNT_W'(POLL_LIMIT - 1);

    ctl_state_e        state;
    op_e               op_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [DATA_W-1:0] data_q;
    logic [2:0]        step;
    logic [PCNT_W-1:0] polls;
    logic              first_tog_q;
    result_e           result;

    logic              bus_req;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data;
    logic              bus_ack;
    logic [DATA_W-1:0] bus_rd;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_last;

    logic              settled;
    logic              timed_out;
    logic              erased_ok;
    ctl_state_e        after_settle;

    fpc_cmd_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cmd (
        .op       (op_q),
        .step     (step),
        .target   (tgt_q),
        .wdata    (data_q),
        .cyc_addr (cmd_addr),
        .cyc_data (cmd_data),
        .cyc_last (cmd_last)
    );

    fpc_bus_engine #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WR_LOW_CLKS (WR_LOW_CLKS),
        .RD_ACC_CLKS (RD_ACC_CLKS)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .req      (bus_req),
        .req_wr   (bus_wr),
        .req_addr (bus_addr),
        .req_data (bus_data),
        .ack      (bus_ack),
        .rd_data  (bus_rd),
        .f_addr   (f_addr),
        .f_dq_o   (f_dq_o),
        .f_dq_oe  (f_dq_oe),
        .f_dq_i   (f_dq_i),
        .f_ce_n   (f_ce_n),
        .f_oe_n   (f_oe_n),
        .f_we_n   (f_we_n)
    );

    fpc_status_judge #(
        .DATA_W (DATA_W)
    ) u_judge (
        .first_tog (first_tog_q),
        .second    (bus_rd),
        .settled   (settled),
        .timed_out (timed_out),
        .erased_ok (erased_ok)
    );

    always_comb begin
        bus_req = (state != C_IDLE) && (state != C_DONE);
        bus_wr  = (state == C_CMD) || (state == C_ABORT);
        case (state)
            C_CMD:   begin bus_addr = cmd_addr; bus_data = cmd_data; end
            C_ABORT: begin bus_addr = '0;       bus_data = DATA_W'(BYTE_RESET); end
            default: begin bus_addr = tgt_q;    bus_data = '0; end
        endcase
        after_settle = (op_q == OP_ERASE) ? C_VERIFY : C_DONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= C_IDLE;
            op_q        <= OP_PROGRAM;
            tgt_q       <= '0;
            data_q      <= '0;
            step        <= '0;
            polls       <= '0;
            first_tog_q <= 1'b0;
            result      <= RES_NONE;
        end else begin
            case (state)
                C_IDLE: begin
                    if (start) begin
                        op_q   <= op_e'(op_erase);
                        tgt_q  <= tgt_addr;
                        data_q <= wr_data;
                        step   <= '0;
                        polls  <= '0;
                        result <= RES_NONE;
                        state  <= C_CMD;
                    end
                end
                C_CMD: begin
                    if (bus_ack) begin
                        if (cmd_last) state <= C_POLL1;
                        else          step  <= step + 1'b1;
                    end
                end
                C_POLL1: begin
                    if (bus_ack) begin
                        first_tog_q <= bus_rd[BIT_TOGGLE];
                        state       <= C_POLL2;
                    end
                end
                C_POLL2: begin
                    if (bus_ack) begin
                        if (settled) begin
                            state <= after_settle;
                            if (op_q == OP_PROGRAM) result <= RES_PASS;
                        end else if (timed_out) begin
                            state <= C_CONF1;
                        end else if (polls == POLL_LAST) begin
                            state <= C_ABORT;
                        end else begin
                            polls <= polls + 1'b1;
                            state <= C_POLL1;
                        end
                    end
                end
                C_CONF1: begin
                    if (bus_ack) begin
                        first_tog_q <= bus_rd[BIT_TOGGLE];
                        state       <= C_CONF2;
                    end
                end
                C_CONF2: begin
                    if (bus_ack) begin
                        if (settled) begin
                            state <= after_settle;
                            if (op_q == OP_PROGRAM) result <= RES_PASS;
                        end else begin
                            state <= C_ABORT;
                        end
                    end
                end
                C_VERIFY: begin
                    if (bus_ack) begin
                        if (erased_ok) begin
                            result <= RES_PASS;
                            state  <= C_DONE;
                        end else begin
                            state <= C_ABORT;
                        end
                    end
                end
                C_ABORT: begin
                    if (bus_ack) begin
                        result <= RES_FAIL;
                        state  <= C_DONE;
                    end
                end
                C_DONE:  state <= C_IDLE;
                default: state <= C_IDLE;
            endcase
        end
    end

    always_comb begin
        done = (state == C_DONE);
        pass = (result == RES_PASS);
        fail = (result == RES_FAIL);
    end

endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int WR_LOW_CLKS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic [ADDR_W-1:0] f_addr,
    input logic [DATA_W-1:0] f_dq_o,
    input logic              f_dq_oe,
    input logic              f_ce_n,
    input logic              f_oe_n,
    input logic              f_we_n
);

    logic [15:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst)          we_low_cnt <= '0;
        else if (!f_we_n) we_low_cnt <= we_low_cnt + 1'b1;
        else              we_low_cnt <= '0;
    end

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst) !f_we_n |-> (!f_ce_n && f_oe_n)); // R4
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst) f_dq_oe |-> f_oe_n); // R4
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(f_we_n) |-> (we_low_cnt == 16'(WR_LOW_CLKS))); // R4
    AST_WE_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst) $rose(f_we_n) |-> ($stable(f_addr) && $stable(f_dq_o))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
    AST_DONE_RESULT: assert property (@(posedge clk) disable iff (rst) done |-> (pass ^ fail)); // R11
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst) !(pass && fail)); // R11
    AST_PASS_HELD: assert property (@(posedge clk) disable iff (rst) (pass && !start) |=> pass); // R11
    AST_FAIL_HELD: assert property (@(posedge clk) disable iff (rst) (fail && !start) |=> fail); // R11

endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WR_LOW_CLKS (WR_LOW_CLKS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .pass    (pass),
    .fail    (fail),
    .f_addr  (f_addr),
    .f_dq_o  (f_dq_o),
    .f_dq_oe (f_dq_oe),
    .f_ce_n  (f_ce_n),
    .f_oe_n  (f_oe_n),
    .f_we_n  (f_we_n)
);

// File: tb/flash_poll_ctrl_test.sv
`timescale 1ns/1ps
module flash_poll_ctrl_test;

    localparam int AW = 17;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          op_erase = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          done, pass, fail;
    logic [AW-1:0] f_addr;
    logic [DW-1:0] f_dq_o, f_dq_i;
    logic          f_dq_oe, f_ce_n, f_oe_n, f_we_n;

    always #2.5 clk = ~clk;

    flash_poll_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .WR_LOW_CLKS(2), .RD_ACC_CLKS(2), .POLL_LIMIT(8)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .op_erase(op_erase),
        .tgt_addr(tgt_addr), .wr_data(wr_data), .done(done), .pass(pass), .fail(fail),
        .f_addr(f_addr), .f_dq_o(f_dq_o), .f_dq_oe(f_dq_oe), .f_dq_i(f_dq_i),
        .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_we_n(f_we_n)
    );

    // ---------------- flash behaviour model ----------------
    int            ridx = 0;
    int            n_wr = 0;
    int            m_ntog = 0;
    int            m_io5 = 255;
    logic [7:0]    m_final = 8'h00;
    logic          mdl_clr = 1'b1;
    logic          prev_oe = 1'b1;
    logic          prev_we = 1'b1;
    logic [AW-1:0] wa [16];
    logic [7:0]    wd [16];

    always @(negedge clk) begin
        if (mdl_clr) begin
            ridx = 0;
            n_wr = 0;
        end else begin
            if (!prev_oe && f_oe_n) ridx = ridx + 1;
            if (!prev_we && f_we_n) begin
                if (n_wr < 16) begin
                    wa[n_wr] = f_addr;
                    wd[n_wr] = f_dq_o;
                end
                n_wr = n_wr + 1;
            end
        end
        prev_oe = f_oe_n;
        prev_we = f_we_n;
    end

    logic [7:0] busy_byte;
    always_comb begin
        busy_byte = 8'h00;
        busy_byte[6] = ridx[0];
        busy_byte[5] = (ridx >= m_io5);
    end
    assign f_dq_i = (!f_ce_n && !f_oe_n) ? ((ridx < m_ntog) ? busy_byte : m_final) : 8'h00;

    // ---------------- bookkeeping ----------------
    int n_checks = 0;
    int n_bad    = 0;
    int cyc      = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
            $finish;
        end
    end

    // expected write k of a run, from R2/R3/R9
    function automatic logic [AW+7:0] exp_wr(input logic op, input int k, input logic [AW-1:0] a, input logic [7:0] d);
        int len;
        len = op ? 6 : 4;
        if (k == len) return {17'h0, 8'hF0};
        if (!op) begin
            case (k)
                0: return {17'h555, 8'hAA};
                1: return {17'h2AA, 8'h55};
                2: return {17'h555, 8'hA0};
                default: return {a, d};
            endcase
        end else begin
            case (k)
                0: return {17'h555, 8'hAA};
                1: return {17'h2AA, 8'h55};
                2: return {17'h555, 8'h80};
                3: return {17'h555, 8'hAA};
                4: return {17'h2AA, 8'h55};
                default: return {a, 8'h30};
            endcase
        end
    endfunction

    task automatic launch(input logic op, input logic [AW-1:0] a, input logic [7:0] d,
                          input int ntog, input int io5, input logic [7:0] fin);
        @(negedge clk);
        #1;
        mdl_clr = 1'b1;
        m_ntog  = ntog;
        m_io5   = io5;
        m_final = fin;
        @(negedge clk);
        #1;
        mdl_clr  = 1'b0;
        op_erase = op;
        tgt_addr = a;
        wr_data  = d;
        start    = 1'b1;
        @(negedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(seen, "R11 done pulse arrives", seen, 1);
    endtask

    typedef struct packed {
        logic          op;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [7:0]    ntog;
        logic [7:0]    io5_at;
        logic [7:0]    final_v;
        logic          exp_pass;
        logic [7:0]    exp_reads;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 17'h01234, 8'h5A, 8'd0,   8'd255, 8'h5A, 1'b1, 8'd2},  // R5 settles on first pair
        '{1'b0, 17'h1FFFF, 8'hA5, 8'd4,   8'd255, 8'hA5, 1'b1, 8'd6},  // R6 two toggling pairs then settle
        '{1'b1, 17'h0C000, 8'h00, 8'd6,   8'd255, 8'hFF, 1'b1, 8'd9},  // R8 erase good read-back
        '{1'b1, 17'h04000, 8'h00, 8'd2,   8'd255, 8'h7F, 1'b0, 8'd5},  // R8 erase bad read-back, R9
        '{1'b0, 17'h00010, 8'h3C, 8'd4,   8'd3,   8'h3C, 1'b1, 8'd6},  // R7 bit5 rises as toggling stops
        '{1'b0, 17'h00020, 8'hC3, 8'd100, 8'd3,   8'hC3, 1'b0, 8'd6},  // R7 still toggling, R9
        '{1'b0, 17'h00030, 8'h11, 8'd100, 8'd255, 8'h11, 1'b0, 8'd16}, // R10 limit reached
        '{1'b0, 17'h00040, 8'h22, 8'd14,  8'd255, 8'h22, 1'b1, 8'd16}, // R10 settles one pair before limit
        '{1'b0, 17'h00050, 8'h33, 8'd16,  8'd255, 8'h33, 1'b0, 8'd16}, // R10 settles exactly at limit
        '{1'b1, 17'h1C000, 8'h00, 8'd2,   8'd1,   8'hFF, 1'b1, 8'd5}   // R7 and R3 erase with confirmation
    };

    initial begin
        bit seen;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(f_ce_n && f_oe_n && f_we_n, "R1 strobes idle in reset", {f_ce_n, f_oe_n, f_we_n}, 3'b111);
        check(!f_dq_oe, "R1 data not driven in reset", f_dq_oe, 0);
        check(!done && !pass && !fail, "R1 status clear in reset", {done, pass, fail}, 0);
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        check(f_ce_n && f_oe_n && f_we_n && !f_dq_oe, "R1 idle after reset",
              {f_ce_n, f_oe_n, f_we_n, f_dq_oe}, 4'b1110);

        foreach (VECS[vi]) begin
            vec_t v;
            int   nexp;
            v = VECS[vi];
            launch(v.op, v.addr, v.data, int'(v.ntog), int'(v.io5_at), v.final_v);
            wait_done(seen);
            check(pass == v.exp_pass, $sformatf("R5/R7/R8/R10 pass, vector %0d", vi), pass, v.exp_pass);
            check(fail == !v.exp_pass, $sformatf("R7/R8/R10 fail, vector %0d", vi), fail, !v.exp_pass);
            @(negedge clk);
            check(!done, $sformatf("R11 done one cycle, vector %0d", vi), done, 0);
            check(ridx == int'(v.exp_reads), $sformatf("R6/R10 status read count, vector %0d", vi), ridx, v.exp_reads);
            nexp = (v.op ? 6 : 4) + (v.exp_pass ? 0 : 1);
            check(n_wr == nexp, $sformatf("R2/R3/R9 write count, vector %0d", vi), n_wr, nexp);
            for (int k = 0; k < nexp && k < n_wr; k++) begin
                logic [AW+7:0] e;
                e = exp_wr(v.op, k, v.addr, v.data);
                check({wa[k], wd[k]} == e, $sformatf("R2/R3/R9 write %0d, vector %0d", k, vi), {wa[k], wd[k]}, e);
            end
        end

        // R12: start while busy is ignored
        launch(1'b0, 17'h00060, 8'h44, 100, 255, 8'h44);
        repeat (20) @(negedge clk);
        #1;
        op_erase = 1'b1;
        tgt_addr = 17'h00001;
        wr_data  = 8'h99;
        start    = 1'b1;
        @(negedge clk);
        #1 start = 1'b0;
        wait_done(seen);
        check(fail && !pass, "R12 result unaffected by busy start", {pass, fail}, 2'b01);
        @(negedge clk);
        check(n_wr == 5, "R12 write count unaffected", n_wr, 5);
        check({wa[3], wd[3]} == {17'h00060, 8'h44}, "R12 program write kept", {wa[3], wd[3]}, {17'h00060, 8'h44});
        check(ridx == 16, "R12 read count unaffected", ridx, 16);

        // R11: result held while idle, cleared on next accepted start
        repeat (5) @(negedge clk);
        check(fail && !pass, "R11 result held while idle", {pass, fail}, 2'b01);
        @(negedge clk);
        #1;
        mdl_clr  = 1'b1;
        m_ntog   = 0;
        m_io5    = 255;
        m_final  = 8'h66;
        @(negedge clk);
        #1;
        mdl_clr  = 1'b0;
        op_erase = 1'b0;
        tgt_addr = 17'h00070;
        wr_data  = 8'h66;
        start    = 1'b1;
        @(negedge clk);
        #1 start = 1'b0;
        check(!pass && !fail, "R11 result cleared on accepted start", {pass, fail}, 0);
        wait_done(seen);
        check(pass && !fail, "R5 program pass after clear", {pass, fail}, 2'b10);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

endmodule